// File: doc/BRIEF.md
# NAND Command and Address Front-End

This block sits on the byte-wide bus of a small-page NAND flash device model. It samples an 8-bit I/O bus together with a command-latch strobe, an address-latch strobe, an active-low chip enable and an active-low write-protect pin. It sorts every bus write into a command, address or data cycle. The block then keeps the current operation code, builds a little-endian multi-byte address and tracks the column offset that the read-pointer commands select.

The back-end (array, page buffer, status byte) reads the latched command, address, address-cycle count and column offset. It reacts to two single-cycle pulses: one when a command that takes no address has been accepted, and one when the address phase of the current command is complete. Data cycles are forwarded as a one-cycle strobe with the byte. The write-protect level is exposed as a registered "writes allowed" flag, which the back-end places in bit 7 of its status byte.

Top module: `nand_fe_top`

## Requirements
- R1: A write (`wr_en` high) with `ce_n` high is ignored. With `ce_n` low it is a command cycle when `cle` is high (this wins over `ale`), an address cycle when only `ale` is high, and a data cycle when both are low. A data cycle gives `data_stb` high for one cycle, with `data_out` equal to the byte, on the cycle after the write.
- R2: A command cycle stores its code in `cur_cmd` from the next cycle on. Codes outside the known set are stored unchanged as well.
- R3: Code 0x00 sets `col_off` to 0. Code 0x01 sets `col_off` to half the page (256) and is stored as 0x00. Code 0x50 sets `col_off` to the page size (512, the spare area) and is stored as 0x00.
- R4: Every command code other than 0x00, 0x01 and 0x50 leaves `col_off` unchanged.
- R5: A command clears `addr_out` and `addr_cnt` to zero, except codes 0x70, 0x10, 0x60, 0xD0 and 0xFF, which keep both.
- R6: An address cycle ORs its byte into `addr_out` at bit 8*`addr_cnt`, then increments `addr_cnt`. Once `ADDR_BYTES` (4) bytes have been taken, further address bytes change nothing.
- R7: `addr_done` pulses on the cycle after the address byte that raises `addr_cnt` to the target of the current command: 1 for 0x90, 3 for 0x00, 0x80 and 0x85, and 2 for 0x60. Other commands never raise it.
- R8: `cmd_done` pulses on the cycle after a command cycle carrying 0xFF, 0x70, 0x10 or 0xD0. It stays low for every other code, including unknown ones.
- R9: `prot_ok` equals `wp_n` as sampled on the previous clock edge, and is 0 in reset.
- R10: Data cycles and ignored writes leave `cur_cmd`, `col_off`, `addr_out` and `addr_cnt` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One-cycle bus write strobe |
| ce_n | input | 1 | Chip enable, active low |
| cle | input | 1 | Command latch strobe |
| ale | input | 1 | Address latch strobe |
| wp_n | input | 1 | Write protect, active low |
| io_in | input | 8 | Bus byte |
| cur_cmd | output | 8 | Latched operation code |
| col_off | output | 10 | Column offset selected by the read-pointer commands |
| addr_out | output | 32 | Accumulated address |
| addr_cnt | output | 3 | Address bytes taken since the last clearing command |
| cmd_done | output | 1 | Pulse: command without an address phase accepted |
| addr_done | output | 1 | Pulse: address phase of the current command complete |
| data_stb | output | 1 | Pulse: data cycle seen |
| data_out | output | 8 | Byte of the last data cycle |
| prot_ok | output | 1 | Registered write-protect level (1 = writes allowed) |

## Verification
On every cycle the assertions check the following. At most one cycle class is active at a time. The address count never exceeds its limit and steps by exactly one per accepted address byte. A clearing command empties the address. The read-second-half alias lands on code 0x00 with offset 256. Codes outside the pointer group hold the column offset. Data cycles leave the state alone, and `prot_ok` tracks `wp_n`. Whether `addr_done` comes on the right byte for each command, whether the kept-address commands really carry a partially built address forward, and whether unknown codes stay silent depend on the order of commands. Only the bench's directed sequences and its long random mix against a reference model can show those.

// File: rtl/nand_fe_pkg.sv
package nand_fe_pkg;

  localparam logic [7:0] OP_READ       = 8'h00;
  localparam logic [7:0] OP_READ_HI    = 8'h01;
  localparam logic [7:0] OP_READ_SPARE = 8'h50;
  localparam logic [7:0] OP_IDENT      = 8'h90;
  localparam logic [7:0] OP_RESET      = 8'hFF;
  localparam logic [7:0] OP_PROG       = 8'h80;
  localparam logic [7:0] OP_PROG_GO    = 8'h10;
  localparam logic [7:0] OP_ERASE      = 8'h60;
  localparam logic [7:0] OP_ERASE_GO   = 8'hD0;
  localparam logic [7:0] OP_STATUS     = 8'h70;
  localparam logic [7:0] OP_COPY       = 8'h85;

  typedef enum logic [1:0] {
    CYC_IDLE,
    CYC_CMD,
    CYC_ADDR,
    CYC_DATA
  } cyc_kind_e;

  // number of address bytes that close the address phase (0: none)
  function automatic logic [2:0] addr_need(input logic [7:0] op);
    case (op)
      OP_IDENT:                   addr_need = 3'd1;
      OP_ERASE:                   addr_need = 3'd2;
      OP_READ, OP_PROG, OP_COPY:  addr_need = 3'd3;
      default:                    addr_need = 3'd0;
    endcase
  endfunction

  // commands that carry the address built so far
  function automatic logic keeps_addr(input logic [7:0] op);
    case (op)
      OP_STATUS, OP_PROG_GO, OP_ERASE, OP_ERASE_GO, OP_RESET: keeps_addr = 1'b1;
      default:                                                 keeps_addr = 1'b0;
    endcase
  endfunction

  // commands complete on their own command cycle
  function automatic logic is_immediate(input logic [7:0] op);
    case (op)
      OP_STATUS, OP_PROG_GO, OP_ERASE_GO, OP_RESET: is_immediate = 1'b1;
      default:                                       is_immediate = 1'b0;
    endcase
  endfunction

  function automatic logic is_pointer(input logic [7:0] op);
    is_pointer = (op == OP_READ) || (op == OP_READ_HI) || (op == OP_READ_SPARE);
  endfunction

  // code kept after aliasing of the read-pointer group
  function automatic logic [7:0] canon_op(input logic [7:0] op);
    canon_op = is_pointer(op) ? OP_READ : op;
  endfunction

endpackage

// File: rtl/nand_fe_classify.sv
module nand_fe_classify
  import nand_fe_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_en,
  input  logic      ce_n,
  input  logic      cle,
  input  logic      ale,
  output cyc_kind_e kind,
  output logic      cmd_cyc,
  output logic      addr_cyc,
  output logic      data_cyc
);

  always_comb begin
    kind = CYC_IDLE;
    if (wr_en && !ce_n) begin
      if (cle)      kind = CYC_CMD;
      else if (ale) kind = CYC_ADDR;
      else          kind = CYC_DATA;
    end
  end

  assign cmd_cyc  = (kind == CYC_CMD);
  assign addr_cyc = (kind == CYC_ADDR);
  assign data_cyc = (kind == CYC_DATA);

  // R1: exactly one class at most, and none without chip enable
  p_class_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_cyc, addr_cyc, data_cyc}));
  p_ce_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> !(cmd_cyc || addr_cyc || data_cyc));

endmodule

// File: rtl/nand_fe_cmd_reg.sv
module nand_fe_cmd_reg
  import nand_fe_pkg::*;
#(
  parameter int PAGE_BYTES = 512,
  parameter int COL_W      = $clog2(PAGE_BYTES) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_cyc,
  input  logic [7:0]       io_in,
  output logic [7:0]       cmd_q,
  output logic [COL_W-1:0] col_q,
  output logic             cmd_done_q,
  output logic             clear_addr
);

  localparam logic [COL_W-1:0] COL_HALF  = COL_W'(PAGE_BYTES / 2);
  localparam logic [COL_W-1:0] COL_SPARE = COL_W'(PAGE_BYTES);

  function automatic logic [COL_W-1:0] next_col(input logic [7:0] op,
                                               input logic [COL_W-1:0] cur);
    case (op)
      OP_READ:       next_col = '0;
      OP_READ_HI:    next_col = COL_HALF;
      OP_READ_SPARE: next_col = COL_SPARE;
      default:       next_col = cur;
    endcase
  endfunction

  assign clear_addr = cmd_cyc && !keeps_addr(io_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q      <= OP_READ;
      col_q      <= '0;
      cmd_done_q <= 1'b0;
    end else begin
      cmd_done_q <= cmd_cyc && is_immediate(io_in);
      if (cmd_cyc) begin
        cmd_q <= canon_op(io_in);
        col_q <= next_col(io_in, col_q);
      end
    end
  end

  // R3: second-half pointer is stored as a plain read at half page
  p_alias_half_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_cyc && io_in == OP_READ_HI) |=> (cmd_q == OP_READ && col_q == COL_HALF));
  // R3: spare pointer lands on the page size
  p_alias_spare_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_cyc && io_in == OP_READ_SPARE) |=> (cmd_q == OP_READ && col_q == COL_SPARE));
  // R4: other codes hold the column offset
  p_col_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_cyc && !is_pointer(io_in)) |=> $stable(col_q));
  // R8: nothing but a command cycle raises the completion pulse
  p_cdone_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_cyc |=> !cmd_done_q);

endmodule

// File: rtl/nand_fe_addr_acc.sv
module nand_fe_addr_acc
  import nand_fe_pkg::*;
#(
  parameter int ADDR_BYTES = 4,
  parameter int ADDR_W     = 8 * ADDR_BYTES,
  parameter int CNT_W      = $clog2(ADDR_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_addr,
  input  logic              addr_cyc,
  input  logic [7:0]        io_in,
  input  logic [7:0]        cur_op,
  output logic [ADDR_W-1:0] addr_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              addr_done_q
);

  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(ADDR_BYTES);

  logic             take_byte;
  logic [CNT_W:0]   cnt_next;
  logic [2:0]       need;
  logic             phase_end;

  assign take_byte = addr_cyc && (cnt_q < CNT_MAX);
  assign cnt_next  = {1'b0, cnt_q} + 1'b1;
  assign need      = addr_need(cur_op);
  assign phase_end = take_byte && (need != 3'd0) && (cnt_next == (CNT_W+1)'(need));

  for (genvar b = 0; b < ADDR_BYTES; b++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        addr_q[8*b +: 8] <= 8'h00;
      else if (clear_addr)
        addr_q[8*b +: 8] <= 8'h00;
      else if (take_byte && cnt_q == CNT_W'(b))
        addr_q[8*b +: 8] <= addr_q[8*b +: 8] | io_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q       <= '0;
      addr_done_q <= 1'b0;
    end else begin
      addr_done_q <= phase_end;
      if (clear_addr)     cnt_q <= '0;
      else if (take_byte) cnt_q <= cnt_next[CNT_W-1:0];
    end
  end

  // R6: count never passes the address width
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_MAX);
  // R6: one step per accepted byte
  p_cnt_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_cyc && cnt_q < CNT_MAX) |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));
  // R5: a clearing command empties the address
  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clear_addr |=> (addr_q == '0 && cnt_q == '0));
  // R7: identification ends after its first address byte
  p_id_one_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_cyc && cur_op == OP_IDENT && cnt_q == '0) |=> addr_done_q);

endmodule

// File: rtl/nand_fe_top.sv
module nand_fe_top
  import nand_fe_pkg::*;
#(
  parameter int PAGE_BYTES = 512,
  parameter int ADDR_BYTES = 4,
  parameter int COL_W      = $clog2(PAGE_BYTES) + 1,
  parameter int ADDR_W     = 8 * ADDR_BYTES,
  parameter int CNT_W      = $clog2(ADDR_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              ce_n,
  input  logic              cle,
  input  logic              ale,
  input  logic              wp_n,
  input  logic [7:0]        io_in,
  output logic [7:0]        cur_cmd,
  output logic [COL_W-1:0]  col_off,
  output logic [ADDR_W-1:0] addr_out,
  output logic [CNT_W-1:0]  addr_cnt,
  output logic              cmd_done,
  output logic              addr_done,
  output logic              data_stb,
  output logic [7:0]        data_out,
  output logic              prot_ok
);

  cyc_kind_e kind;
  logic      cmd_cyc, addr_cyc, data_cyc;
  logic      clear_addr;
  logic      past_ok;

  nand_fe_classify u_class (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .ce_n     (ce_n),
    .cle      (cle),
    .ale      (ale),
    .kind     (kind),
    .cmd_cyc  (cmd_cyc),
    .addr_cyc (addr_cyc),
    .data_cyc (data_cyc)
  );

  nand_fe_cmd_reg #(.PAGE_BYTES(PAGE_BYTES), .COL_W(COL_W)) u_cmd (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_cyc    (cmd_cyc),
    .io_in      (io_in),
    .cmd_q      (cur_cmd),
    .col_q      (col_off),
    .cmd_done_q (cmd_done),
    .clear_addr (clear_addr)
  );

  nand_fe_addr_acc #(.ADDR_BYTES(ADDR_BYTES), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_addr (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear_addr  (clear_addr),
    .addr_cyc    (addr_cyc),
    .io_in       (io_in),
    .cur_op      (cur_cmd),
    .addr_q      (addr_out),
    .cnt_q       (addr_cnt),
    .addr_done_q (addr_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_stb <= 1'b0;
      data_out <= 8'h00;
      prot_ok  <= 1'b0;
      past_ok  <= 1'b0;
    end else begin
      data_stb <= data_cyc;
      if (data_cyc) data_out <= io_in;
      prot_ok  <= wp_n;
      past_ok  <= 1'b1;
    end
  end

  // R9: protect flag follows the pin one edge later
  p_wp_track_r9: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> prot_ok == $past(wp_n));
  // R10: data and idle cycles leave the command state alone
  p_data_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == CYC_DATA || kind == CYC_IDLE) |=>
      ($stable(cur_cmd) && $stable(col_off) && $stable(addr_out) && $stable(addr_cnt)));
  // R7 R8: the two completion pulses never coincide
  p_pulse_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_done && addr_done));

endmodule

// File: tb/nand_fe_top_tb.sv
`timescale 1ns/1ps
module nand_fe_top_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, ce_n = 1'b1, cle = 1'b0, ale = 1'b0, wp_n = 1'b1;
  logic [7:0]  io_in = 8'h00;
  logic [7:0]  cur_cmd;
  logic [9:0]  col_off;
  logic [31:0] addr_out;
  logic [2:0]  addr_cnt;
  logic        cmd_done, addr_done, data_stb, prot_ok;
  logic [7:0]  data_out;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // expected state
  logic [7:0]  e_cmd = 8'h00;
  logic [9:0]  e_col = 10'd0;
  logic [31:0] e_addr = 32'd0;
  int          e_cnt = 0;
  logic        e_cd = 0, e_ad = 0, e_ds = 0, e_prot = 0;
  logic [7:0]  e_dout = 8'h00;

  always #4 clk = ~clk;

  nand_fe_top u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .ce_n(ce_n), .cle(cle), .ale(ale),
    .wp_n(wp_n), .io_in(io_in), .cur_cmd(cur_cmd), .col_off(col_off),
    .addr_out(addr_out), .addr_cnt(addr_cnt), .cmd_done(cmd_done),
    .addr_done(addr_done), .data_stb(data_stb), .data_out(data_out),
    .prot_ok(prot_ok)
  );

  function automatic int tb_need(input logic [7:0] c);
    if (c == 8'h90) return 1;
    if (c == 8'h60) return 2;
    if (c == 8'h00 || c == 8'h80 || c == 8'h85) return 3;
    return 0;
  endfunction

  function automatic bit tb_keep(input logic [7:0] c);
    return c inside {8'h70, 8'h10, 8'h60, 8'hD0, 8'hFF};
  endfunction

  function automatic bit tb_imm(input logic [7:0] c);
    return c inside {8'h70, 8'h10, 8'hD0, 8'hFF};
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R2 cur_cmd", 32'(cur_cmd), 32'(e_cmd));
    chk("R3 R4 col_off", 32'(col_off), 32'(e_col));
    chk("R5 R6 addr_out", addr_out, e_addr);
    chk("R5 R6 addr_cnt", 32'(addr_cnt), 32'(e_cnt));
    chk("R7 addr_done", 32'(addr_done), 32'(e_ad));
    chk("R8 cmd_done", 32'(cmd_done), 32'(e_cd));
    chk("R1 data_stb", 32'(data_stb), 32'(e_ds));
    if (e_ds) chk("R1 data_out", 32'(data_out), 32'(e_dout));
    chk("R9 prot_ok", 32'(prot_ok), 32'(e_prot));
  endtask

  // one bus write, then one idle cycle
  task automatic bus(input bit we, input bit cen, input bit c, input bit a,
                     input logic [7:0] v, input bit wp);
    @(negedge clk);
    wr_en = we; ce_n = cen; cle = c; ale = a; io_in = v; wp_n = wp;
    @(posedge clk);
    e_cd = 0; e_ad = 0; e_ds = 0; e_prot = wp;
    if (we && !cen) begin
      if (c) begin
        if (v == 8'h00) e_col = 10'd0;
        else if (v == 8'h01) e_col = 10'd256;
        else if (v == 8'h50) e_col = 10'd512;
        if (!tb_keep(v)) begin e_addr = 0; e_cnt = 0; end
        e_cmd = (v == 8'h01 || v == 8'h50) ? 8'h00 : v;
        e_cd = tb_imm(v);
      end else if (a) begin
        if (e_cnt < 4) begin
          e_addr = e_addr | (32'(v) << (8 * e_cnt));
          e_ad = (tb_need(e_cmd) != 0) && (e_cnt + 1 == tb_need(e_cmd));
          e_cnt++;
        end
      end else begin
        e_ds = 1; e_dout = v;
      end
    end
    @(negedge clk);
    check_all();
    wr_en = 0;
    e_cd = 0; e_ad = 0; e_ds = 0;
    @(negedge clk);
    check_all();
  endtask

  task automatic cmd(input logic [7:0] v); bus(1, 0, 1, 0, v, 1); endtask
  task automatic adr(input logic [7:0] v); bus(1, 0, 0, 1, v, 1); endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // reset state
    check_all();
    chk("R9 prot_ok in reset", 32'(prot_ok), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    e_prot = 1;

    // R3 pointer group
    cmd(8'h50);
    cmd(8'h01);
    cmd(8'h00);
    // R7 identification: one byte
    cmd(8'h90); adr(8'hEC);
    // R6 R7 read: done on third, saturation after four
    cmd(8'h00); adr(8'h11); adr(8'h22); adr(8'h33); adr(8'h44); adr(8'h55);
    // R5 R8 status keeps address
    cmd(8'h70);
    // R10 data cycle
    bus(1, 0, 0, 0, 8'hAB, 1);
    // R1 chip disabled, and write strobe low
    bus(1, 1, 1, 0, 8'h90, 1);
    bus(0, 0, 1, 0, 8'h80, 1);
    // R1 cle wins over ale
    bus(1, 0, 1, 1, 8'h80, 1);
    // R7 erase after clearing: two row bytes
    cmd(8'h00); cmd(8'h60); adr(8'h01); adr(8'h02); cmd(8'hD0);
    // R2 R4 R8 unknown code
    cmd(8'h50); cmd(8'h3C);
    // R9 protect pin low
    bus(1, 0, 0, 0, 8'h5A, 0);
    bus(0, 0, 0, 0, 8'h00, 1);
    // program and copy-back address phases
    cmd(8'h80); adr(8'hA0); adr(8'hA1); adr(8'hA2); cmd(8'h10);
    cmd(8'h85); adr(8'h0F); adr(8'hF0); adr(8'h3C);
    cmd(8'hFF);

    // constrained random mix
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] v;
      int r, k;
      bit we, cen, c, a, wp;
      r  = $urandom_range(0, 99);
      we = ($urandom_range(0, 9) != 0);
      cen = ($urandom_range(0, 9) == 0);
      c  = (r < 25);
      a  = (r >= 25 && r < 65) || (c && $urandom_range(0, 7) == 0);
      wp = ($urandom_range(0, 5) != 0);
      k  = $urandom_range(0, 12);
      case (k)
        0: v = 8'h00;  1: v = 8'h01;  2: v = 8'h50;  3: v = 8'h90;
        4: v = 8'hFF;  5: v = 8'h80;  6: v = 8'h10;  7: v = 8'h60;
        8: v = 8'hD0;  9: v = 8'h70;  10: v = 8'h85;
        default: v = 8'($urandom);
      endcase
      if (!c) v = 8'($urandom);
      bus(we, cen, c, a, v, wp);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule